// File: doc/BRIEF.md
# ADC Channel Interrupt Status Register

This block keeps the interrupt status of one channel of a sequenced ADC scan controller. Two families of events feed it. Group events (scan finished, scan preempted) are only recorded when the channel is the last one of its group. Channel events (the averaged result met the range condition, the pulse counter ran out) are recorded for every channel. Hardware can only set a status bit. Software clears a bit by writing a one to it on a simple register write port.

On top of the raw events, the block works out two overflow conditions. Group overflow flags a scan completion that arrives while an earlier completion is still unserviced. Channel overflow flags a range or pulse event that repeats while its bit is still pending. It also flags a new conversion result that arrives before the DMA engine has acknowledged pickup of the previous one. For that purpose a data-valid flag is kept internally. The status word can always be read, and a single interrupt line is formed from the status ANDed with a mask input.

Top module: `adc_chan_irq_status`

## Requirements
- R1: The status word has group-done at bit 0, group-cancelled at bit 1, group-overflow at bit 2, channel-range at bit 8, channel-pulse at bit 9 and channel-overflow at bit 10; every other bit reads as 0.
- R2: After reset every status bit is 0 and the interrupt output is low.
- R3: A write with `wr_en` high clears each status bit whose `wr_data` bit is 1, visible one clock later; bits written with 0 keep their value.
- R4: When a hardware set and a software clear hit the same bit in the same cycle, the bit ends up set.
- R5: Group events (done, cancelled) set their bits only in cycles where `last_in_group` is high; otherwise they are ignored.
- R6: A group-done event (with `last_in_group` high) sets group-overflow when group-done is already pending and is not being cleared in that same cycle.
- R7: Group-done and group-cancelled events in the same cycle set both bits together.
- R8: A range strobe sets channel-range and a pulse strobe sets channel-pulse; when both strobes come in the same cycle only channel-range is set.
- R9: A range (or pulse) event sets channel-overflow when its own bit is already pending and is not being cleared in the same cycle.
- R10: A data-valid flag is set by each `result_evt` and cleared by `dma_ack`; a `result_evt` while the flag is set and no `dma_ack` arrives in that cycle sets channel-overflow.
- R11: `irq_out` is high exactly when some bit of `rd_data & irq_mask` is 1, following the mask combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| last_in_group | input | 1 | This channel is the final one of its scan group |
| grp_done_evt | input | 1 | Group scan finished strobe |
| grp_cancel_evt | input | 1 | Group scan preempted strobe |
| rng_evt | input | 1 | Averaged result met the range condition |
| pulse_evt | input | 1 | Positive pulse counter reached zero |
| result_evt | input | 1 | New conversion result available |
| dma_ack | input | 1 | DMA acknowledges pickup of the current result |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 32 | Write-one-to-clear data |
| irq_mask | input | 32 | Interrupt enable mask |
| rd_data | output | 32 | Status word |
| irq_out | output | 1 | Masked interrupt request |

## Verification
Every status bit and the hidden data-valid flag are registers. An event, a clear or an acknowledge presented before a rising edge therefore shows in `rd_data` one clock later. The interrupt output adds no register, so it follows status and mask in the same cycle. The bench drives inputs just after a rising edge, lets exactly one edge pass, and samples one time unit later. A mask change is checked before the next edge, because it acts at once. Directed checks compare against hand-worked constants, and the random phase compares each cycle against a bench model advanced once per edge.

// File: rtl/adc_irq_pkg.sv
package adc_irq_pkg;

  localparam int STAT_W  = 32;
  localparam int B_GDONE = 0;
  localparam int B_GCANC = 1;
  localparam int B_GOVF  = 2;
  localparam int B_CRNG  = 8;
  localparam int B_CPLS  = 9;
  localparam int B_COVF  = 10;

  typedef struct packed {
    logic ovf;
    logic cancel;
    logic done;
  } grp_stat_t;

  typedef struct packed {
    logic ovf;
    logic pls;
    logic rng;
  } ch_stat_t;

  // Sticky bit update: a set always wins over a clear
  function automatic logic sticky_next(logic cur, logic set, logic clr);
    return set | (cur & ~clr);
  endfunction

  // Repeat event on a bit that stays pending through this cycle
  function automatic logic repeat_hit(logic cur, logic set, logic clr);
    return set & cur & ~clr;
  endfunction

  function automatic logic [STAT_W-1:0] impl_mask();
    logic [STAT_W-1:0] m;
    m = '0;
    m[B_GDONE] = 1'b1;
    m[B_GCANC] = 1'b1;
    m[B_GOVF]  = 1'b1;
    m[B_CRNG]  = 1'b1;
    m[B_CPLS]  = 1'b1;
    m[B_COVF]  = 1'b1;
    return m;
  endfunction

  function automatic logic [STAT_W-1:0] pack_status(grp_stat_t g, ch_stat_t c);
    logic [STAT_W-1:0] w;
    w = '0;
    w[B_GDONE] = g.done;
    w[B_GCANC] = g.cancel;
    w[B_GOVF]  = g.ovf;
    w[B_CRNG]  = c.rng;
    w[B_CPLS]  = c.pls;
    w[B_COVF]  = c.ovf;
    return w;
  endfunction

endpackage

// File: rtl/adc_grp_evt.sv
module adc_grp_evt
  import adc_irq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      last_in_group,
  input  logic      done_evt,
  input  logic      cancel_evt,
  input  grp_stat_t clr,
  output grp_stat_t stat,
  output logic      done_set,
  output logic      ovf_set
);

  logic cancel_set;
  grp_stat_t stat_d;

  assign done_set   = done_evt & last_in_group;
  assign cancel_set = cancel_evt & last_in_group;
  assign ovf_set    = repeat_hit(stat.done, done_set, clr.done);

  always_comb begin
    stat_d.done   = sticky_next(stat.done,   done_set,   clr.done);
    stat_d.cancel = sticky_next(stat.cancel, cancel_set, clr.cancel);
    stat_d.ovf    = sticky_next(stat.ovf,    ovf_set,    clr.ovf);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat <= '0;
    else        stat <= stat_d;
  end

endmodule

// File: rtl/adc_ch_evt.sv
module adc_ch_evt
  import adc_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     rng_evt,
  input  logic     pulse_evt,
  input  logic     result_evt,
  input  logic     dma_ack,
  input  ch_stat_t clr,
  output ch_stat_t stat,
  output logic     data_valid,
  output logic     rng_set,
  output logic     pls_set,
  output logic     unacked_hit,
  output logic     ovf_set
);

  logic     rng_rep;
  logic     pls_rep;
  logic     dv_d;
  ch_stat_t stat_d;

  // Range has priority: at most one of the two per result
  assign rng_set     = rng_evt;
  assign pls_set     = pulse_evt & ~rng_evt;
  assign rng_rep     = repeat_hit(stat.rng, rng_set, clr.rng);
  assign pls_rep     = repeat_hit(stat.pls, pls_set, clr.pls);
  assign unacked_hit = result_evt & data_valid & ~dma_ack;
  assign ovf_set     = rng_rep | pls_rep | unacked_hit;
  assign dv_d        = sticky_next(data_valid, result_evt, dma_ack);

  always_comb begin
    stat_d.rng = sticky_next(stat.rng, rng_set, clr.rng);
    stat_d.pls = sticky_next(stat.pls, pls_set, clr.pls);
    stat_d.ovf = sticky_next(stat.ovf, ovf_set, clr.ovf);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat       <= '0;
      data_valid <= 1'b0;
    end else begin
      stat       <= stat_d;
      data_valid <= dv_d;
    end
  end

endmodule

// File: rtl/adc_chan_irq_status.sv
module adc_chan_irq_status
  import adc_irq_pkg::*;
#(
  parameter int REG_W = STAT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             last_in_group,
  input  logic             grp_done_evt,
  input  logic             grp_cancel_evt,
  input  logic             rng_evt,
  input  logic             pulse_evt,
  input  logic             result_evt,
  input  logic             dma_ack,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic [REG_W-1:0] irq_mask,
  output logic [REG_W-1:0] rd_data,
  output logic             irq_out
);

  localparam logic [REG_W-1:0] IMPL = REG_W'(impl_mask());

  logic [REG_W-1:0] clr_word;
  logic             unused_clr;
  grp_stat_t        g_clr, g_stat;
  ch_stat_t         c_clr, c_stat;
  logic             grp_done_set, grp_ovf_set;
  logic             ch_rng_set, ch_pls_set, ch_unacked, ch_ovf_set, ch_dv;

  assign clr_word   = wr_en ? wr_data : '0;
  assign unused_clr = ^(clr_word & ~IMPL);

  assign g_clr.done   = clr_word[B_GDONE];
  assign g_clr.cancel = clr_word[B_GCANC];
  assign g_clr.ovf    = clr_word[B_GOVF];
  assign c_clr.rng    = clr_word[B_CRNG];
  assign c_clr.pls    = clr_word[B_CPLS];
  assign c_clr.ovf    = clr_word[B_COVF];

  adc_grp_evt u_grp (
    .clk           (clk),
    .rst_n         (rst_n),
    .last_in_group (last_in_group),
    .done_evt      (grp_done_evt),
    .cancel_evt    (grp_cancel_evt),
    .clr           (g_clr),
    .stat          (g_stat),
    .done_set      (grp_done_set),
    .ovf_set       (grp_ovf_set)
  );

  adc_ch_evt u_ch (
    .clk         (clk),
    .rst_n       (rst_n),
    .rng_evt     (rng_evt),
    .pulse_evt   (pulse_evt),
    .result_evt  (result_evt),
    .dma_ack     (dma_ack),
    .clr         (c_clr),
    .stat        (c_stat),
    .data_valid  (ch_dv),
    .rng_set     (ch_rng_set),
    .pls_set     (ch_pls_set),
    .unacked_hit (ch_unacked),
    .ovf_set     (ch_ovf_set)
  );

  assign rd_data = REG_W'(pack_status(g_stat, c_stat));
  assign irq_out = |(rd_data & irq_mask);

endmodule

module adc_chan_irq_status_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        last_in_group,
  input logic        grp_done_evt,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic [31:0] rd_data,
  input logic        rng_evt,
  input logic        pulse_evt,
  input logic        result_evt,
  input logic        dma_ack,
  input logic        ch_dv
);

  a_r1_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & 32'hFFFF_F8F8) == 32'h0);

  a_r4_done_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_done_evt && last_in_group) |=> rd_data[0]);

  a_r3_clear_range: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[8] && !rng_evt) |=> !rd_data[8]);

  a_r5_not_last: assert property (@(posedge clk) disable iff (!rst_n)
    (!last_in_group && !rd_data[0]) |=> !rd_data[0]);

  a_r6_grp_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_done_evt && last_in_group && rd_data[0] && !(wr_en && wr_data[0])) |=> rd_data[2]);

  a_r8_range_first: assert property (@(posedge clk) disable iff (!rst_n)
    (rng_evt && pulse_evt && !rd_data[9]) |=> !rd_data[9]);

  a_r10_unacked: assert property (@(posedge clk) disable iff (!rst_n)
    (result_evt && ch_dv && !dma_ack) |=> rd_data[10]);

endmodule

bind adc_chan_irq_status adc_chan_irq_status_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .last_in_group (last_in_group),
  .grp_done_evt  (grp_done_evt),
  .wr_en         (wr_en),
  .wr_data       (wr_data),
  .rd_data       (rd_data),
  .rng_evt       (rng_evt),
  .pulse_evt     (pulse_evt),
  .result_evt    (result_evt),
  .dma_ack       (dma_ack),
  .ch_dv         (ch_dv)
);

// File: tb/adc_chan_irq_status_bench.sv
module adc_chan_irq_status_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        last_in_group = 1'b0, grp_done_evt = 1'b0, grp_cancel_evt = 1'b0;
  logic        rng_evt = 1'b0, pulse_evt = 1'b0, result_evt = 1'b0, dma_ack = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0, irq_mask = '0;
  logic [31:0] rd_data;
  logic        irq_out;

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;
  int wd_cnt = 0;

  logic [31:0] m_st = '0;
  logic        m_dv = 1'b0;

  always #5 clk = ~clk;

  adc_chan_irq_status u_adc_chan_irq_status (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Bench model of one clock edge, from the requirement text
  task automatic model_edge();
    logic [31:0] c, n;
    logic gd, gc, rs, ps;
    c  = wr_en ? wr_data : 32'h0;
    gd = last_in_group && grp_done_evt;
    gc = last_in_group && grp_cancel_evt;
    rs = rng_evt;
    ps = pulse_evt && !rng_evt;
    n = 32'h0;
    n[0]  = gd || (m_st[0] && !c[0]);
    n[1]  = gc || (m_st[1] && !c[1]);
    n[2]  = (gd && m_st[0] && !c[0]) || (m_st[2] && !c[2]);
    n[8]  = rs || (m_st[8] && !c[8]);
    n[9]  = ps || (m_st[9] && !c[9]);
    n[10] = (rs && m_st[8] && !c[8]) || (ps && m_st[9] && !c[9]) ||
            (result_evt && m_dv && !dma_ack) || (m_st[10] && !c[10]);
    m_dv = result_evt ? 1'b1 : (dma_ack ? 1'b0 : m_dv);
    m_st = n;
  endtask

  task automatic step(input logic lg, gd, gc, rg, pl, rs, ak, we, input logic [31:0] wd);
    last_in_group = lg; grp_done_evt = gd; grp_cancel_evt = gc;
    rng_evt = rg; pulse_evt = pl; result_evt = rs; dma_ack = ak;
    wr_en = we; wr_data = wd;
    model_edge();
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    wd_cnt++;
    if (wd_cnt > 50000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected below 50000 cycles", wd_cnt);
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    #1;
    check("R2 reset status", rd_data, 32'h0);
    check("R2 reset irq", {31'h0, irq_out}, 32'h0);
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    irq_mask = 32'hFFFF_FFFF;

    step(0,1,1,0,0,0,0,0,0);           check("R5 group ignored when not last", rd_data, 32'h0);
    step(1,1,0,0,0,0,0,0,0);           check("R1 done at bit0", rd_data, 32'h1);
    step(1,1,0,0,0,0,0,0,0);           check("R6 repeat done overflow", rd_data, 32'h5);
    step(0,0,0,0,0,0,0,1,32'h0);       check("R3 write zero no effect", rd_data, 32'h5);
    step(0,0,0,0,0,0,0,1,32'h5);       check("R3 w1c clears", rd_data, 32'h0);
    step(1,1,1,0,0,0,0,0,0);           check("R7 done and cancel coexist", rd_data, 32'h3);
    step(1,1,0,0,0,0,0,1,32'h1);       check("R4 set beats clear, no R6 ovf", rd_data, 32'h3);
    step(0,0,0,0,0,0,0,1,32'h7);       check("R3 clear group", rd_data, 32'h0);
    step(0,0,0,1,1,0,0,0,0);           check("R8 range beats pulse", rd_data, 32'h100);
    step(0,0,0,0,1,0,0,0,0);           check("R8 pulse bit9", rd_data, 32'h300);
    step(0,0,0,0,1,0,0,0,0);           check("R9 repeat pulse overflow", rd_data, 32'h700);
    step(0,0,0,1,0,0,0,1,32'h700);     check("R9 range with clear no overflow", rd_data, 32'h100);
    step(0,0,0,0,0,1,0,0,0);           check("R10 first result", rd_data, 32'h100);
    step(0,0,0,0,0,1,0,0,0);           check("R10 unacked result overflow", rd_data, 32'h500);
    step(0,0,0,0,0,1,1,1,32'h400);     check("R10 ack with result no overflow", rd_data, 32'h100);
    step(0,0,0,0,0,0,1,0,0);           check("R10 ack alone", rd_data, 32'h100);
    step(0,0,0,0,0,1,0,0,0);           check("R10 result after ack", rd_data, 32'h100);
    irq_mask = 32'h0000_0100; #1;      check("R11 masked bit on", {31'h0, irq_out}, 32'h1);
    irq_mask = 32'hFFFF_FEFF; #1;      check("R11 masked bit off", {31'h0, irq_out}, 32'h0);

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] wd;
      wd = $urandom;
      if ($urandom_range(0, 1) == 1) wd = wd & 32'h0000_0707;
      irq_mask = $urandom;
      step($urandom_range(0,3) != 0, $urandom_range(0,3) == 0, $urandom_range(0,5) == 0,
           $urandom_range(0,3) == 0, $urandom_range(0,3) == 0, $urandom_range(0,2) == 0,
           $urandom_range(0,2) == 0, $urandom_range(0,2) == 0, wd);
      check("R9 R10 R6 random status", rd_data, m_st);
      check("R11 random irq", {31'h0, irq_out}, {31'h0, |(m_st & irq_mask)});
    end
    finish_run();
  end

endmodule